// File: doc/BRIEF.md
# Escaped-Frame Receiver with Diagnostic Counters

This block takes the byte stream from a serial receiver and recovers whole messages from it. Each message sits between delimiter bytes. Two reserved values inside a message travel as two-byte escape sequences, and the block restores them. Each message ends with a 16-bit CRC. The block also checks the first byte of the message against this unit's address. A message that is addressed here is passed out on a byte-wide stream as its bytes arrive, three decoded bytes behind the input. When the closing delimiter arrives, the final beat carries `out_last`. On that beat `out_accept` is high when the message proved good and low when the consumer must drop what it received.

Four saturating counters record problems on the link: broken escapes, runts, oversize messages and CRC mismatches. Each message raises at most one of them. A broken escape takes precedence, then length, then CRC. Runts and CRC mismatches are counted only for messages whose first byte equals the unit's address. A synchronous clear input empties all four counters.

Top module: `esc_frame_rx`

## Requirements
- R1: Byte 0xC0 ends a message. Byte 0xDB followed by 0xDC decodes to the data byte 0xC0, and 0xDB followed by 0xDD decodes to 0xDB. Any other byte is data as it stands.
- R2: For a message whose first decoded byte equals `my_addr`, every decoded byte except the final two (the CRC) appears once on `out_data` with `out_valid`, in order. The final beat of the message carries `out_last`, and each beat appears two clock cycles after the input byte that released it.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first with no final inversion. It covers all bytes before the last two, and it is received low byte first. `out_accept` is high only on the last beat, and only when the CRC matches and the length is between 5 and MAX_FRAME (69 by default) decoded bytes.
- R4: A message whose first byte differs from `my_addr` produces no output beats and never raises the runt or bad-CRC counters.
- R5: A zero-length message, such as two 0xC0 bytes back to back, produces no beats and no counter change.
- R6: A message of 1 to 4 decoded bytes whose first byte equals `my_addr` raises the runt counter by one. If it already produced beats, its last beat has `out_accept` low.
- R7: A message longer than MAX_FRAME decoded bytes raises the oversize counter by one, whatever its address, and is not accepted.
- R8: A message of legal length, addressed here and free of framing errors, whose CRC does not match raises the bad-CRC counter by one.
- R9: An escape byte followed by anything other than 0xDC or 0xDD raises the framing counter once. The rest of the message up to the next 0xC0 is discarded, no other counter moves for it, and any message already being streamed ends with a last beat that has `out_accept` low.
- R10: Each counter is CNT_W bits wide (8 by default) and stays at its maximum (0xFF) instead of wrapping.
- R11: All counters read zero after reset, and one cycle after `cnt_clr` is sampled high. A clear wins over an increment in the same cycle.
- R12: No two counters increment in the same cycle, and a single message raises at most one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| my_addr | input | 8 | Address of this unit, compared with the first decoded byte |
| cnt_clr | input | 1 | Synchronous clear of all four counters |
| in_valid | input | 1 | Raw byte present on `in_byte` |
| in_byte | input | 8 | Raw received byte |
| out_valid | output | 1 | Decoded message byte present on `out_data` |
| out_data | output | 8 | Decoded message byte |
| out_last | output | 1 | Final beat of the current message |
| out_accept | output | 1 | With `out_last`: message is good and should be kept |
| cnt_framing | output | CNT_W | Broken-escape message count |
| cnt_runt | output | CNT_W | Short addressed message count |
| cnt_oversize | output | CNT_W | Over-long message count |
| cnt_badcrc | output | CNT_W | Addressed message CRC mismatch count |

## Verification
On every cycle, the assertions check that accept appears only together with a last beat and that each beat follows an input byte by two cycles. They also check that at most one counter moves at a time, that counters only hold or step by one, that a full counter stays full and that a clear empties all of them. Whether a given message is classified correctly can only be shown by the bench's scenarios. Those scenarios cover escape decoding, the length boundaries at 4/5 and 69/70 bytes, the address gating of runts and CRC errors, the precedence of a broken escape over a bad CRC, and recovery on the next delimiter. They also check the exact beat sequence, including the closing beat of rejected messages.

// File: rtl/esc_rx_pkg.sv
package esc_rx_pkg;
   localparam logic [7:0] CH_END  = 8'hC0;
   localparam logic [7:0] CH_ESC  = 8'hDB;
   localparam logic [7:0] CH_TEND = 8'hDC;
   localparam logic [7:0] CH_TESC = 8'hDD;

   localparam int NUM_EV      = 4;
   localparam int IX_FRAMING  = 0;
   localparam int IX_RUNT     = 1;
   localparam int IX_OVERSIZE = 2;
   localparam int IX_BADCRC   = 3;

   localparam int MIN_FRAME = 5;

   // one byte of CRC-16, polynomial 0x1021, MSB first
   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) begin
         r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/esc_rx_decode.sv
module esc_rx_decode
   import esc_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       dec_valid,
   output logic [7:0] dec_byte,
   output logic       dec_end,
   output logic       dec_ferr
);
   logic esc_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         esc_pend  <= 1'b0;
         dec_valid <= 1'b0;
         dec_byte  <= 8'h00;
         dec_end   <= 1'b0;
         dec_ferr  <= 1'b0;
      end else begin
         dec_valid <= 1'b0;
         dec_end   <= 1'b0;
         dec_ferr  <= 1'b0;
         if (in_valid) begin
            if (esc_pend) begin
               esc_pend <= 1'b0;
               if (in_byte == CH_TEND) begin
                  dec_valid <= 1'b1;
                  dec_byte  <= CH_END;
               end else if (in_byte == CH_TESC) begin
                  dec_valid <= 1'b1;
                  dec_byte  <= CH_ESC;
               end else begin
                  dec_ferr <= 1'b1;
                  dec_end  <= (in_byte == CH_END);
               end
            end else if (in_byte == CH_END) begin
               dec_end <= 1'b1;
            end else if (in_byte == CH_ESC) begin
               esc_pend <= 1'b1;
            end else begin
               dec_valid <= 1'b1;
               dec_byte  <= in_byte;
            end
         end
      end
   end
endmodule

// File: rtl/esc_rx_satcnt.sv
module esc_rx_satcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && (count != {W{1'b1}})) begin
         count <= count + W'(1);
      end
   end
endmodule

// File: rtl/esc_frame_rx.sv
module esc_frame_rx
   import esc_rx_pkg::*;
#(
   parameter int MAX_PAYLOAD  = 64,
   parameter int HDR_TRL      = 5,
   parameter int CNT_W        = 8,
   parameter bit CRC_LOW_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       my_addr,
   input  logic             cnt_clr,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_last,
   output logic             out_accept,
   output logic [CNT_W-1:0] cnt_framing,
   output logic [CNT_W-1:0] cnt_runt,
   output logic [CNT_W-1:0] cnt_oversize,
   output logic [CNT_W-1:0] cnt_badcrc
);
   localparam int MAX_FRAME = MAX_PAYLOAD + HDR_TRL;
   localparam int LEN_W     = $clog2(MAX_FRAME + 1);

   if (MAX_PAYLOAD < 1) begin : g_bad_payload
      $error("esc_frame_rx: MAX_PAYLOAD must be at least 1");
   end
   if (HDR_TRL < MIN_FRAME) begin : g_bad_hdr
      $error("esc_frame_rx: HDR_TRL must cover address, control and CRC");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("esc_frame_rx: CNT_W must be at least 2");
   end

   logic       dec_valid, dec_end, dec_ferr;
   logic [7:0] dec_byte;

   esc_rx_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .dec_valid(dec_valid),
      .dec_byte (dec_byte),
      .dec_end  (dec_end),
      .dec_ferr (dec_ferr)
   );

   // per-message state
   logic [LEN_W-1:0]  len;
   logic              fe, ov, mine, sent;
   logic [7:0]        h0, h1, h2;      // newest .. oldest held bytes
   logic [15:0]       crc;
   logic [NUM_EV-1:0] ev_inc;

   logic [15:0] rx_crc;
   if (CRC_LOW_FIRST) begin : g_crc_lo
      assign rx_crc = {h0, h1};
   end else begin : g_crc_hi
      assign rx_crc = {h1, h0};
   end

   logic crc_ok, mine_n, at_cap, ov_n;
   always_comb begin
      crc_ok = (crc == rx_crc);
      mine_n = (len == '0) ? (dec_byte == my_addr) : mine;
      at_cap = (len == LEN_W'(MAX_FRAME));
      ov_n   = ov | at_cap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len <= '0; fe <= 1'b0; ov <= 1'b0; mine <= 1'b0; sent <= 1'b0;
         h0 <= 8'h00; h1 <= 8'h00; h2 <= 8'h00;
         crc <= 16'hFFFF;
         ev_inc <= '0;
         out_valid <= 1'b0; out_data <= 8'h00; out_last <= 1'b0; out_accept <= 1'b0;
      end else begin
         out_valid  <= 1'b0;
         out_last   <= 1'b0;
         out_accept <= 1'b0;
         ev_inc     <= '0;
         if (dec_ferr) begin
            if (!fe) begin
               ev_inc[IX_FRAMING] <= 1'b1;
               if (sent) begin
                  out_valid <= 1'b1;
                  out_last  <= 1'b1;
                  out_data  <= h2;
               end
            end
            if (dec_end) begin
               len <= '0; fe <= 1'b0; ov <= 1'b0; mine <= 1'b0; sent <= 1'b0;
               crc <= 16'hFFFF;
            end else begin
               fe <= 1'b1;
            end
         end else if (dec_end) begin
            if (!fe && (len != '0)) begin
               if (ov) begin
                  ev_inc[IX_OVERSIZE] <= 1'b1;
               end else if (len < LEN_W'(MIN_FRAME)) begin
                  if (mine) ev_inc[IX_RUNT] <= 1'b1;
               end else if (mine && !crc_ok) begin
                  ev_inc[IX_BADCRC] <= 1'b1;
               end
               if (sent) begin
                  out_valid  <= 1'b1;
                  out_last   <= 1'b1;
                  out_data   <= h2;
                  out_accept <= !ov && (len >= LEN_W'(MIN_FRAME)) && crc_ok;
               end
            end
            len <= '0; fe <= 1'b0; ov <= 1'b0; mine <= 1'b0; sent <= 1'b0;
            crc <= 16'hFFFF;
         end else if (dec_valid && !fe) begin
            mine <= mine_n;
            if (at_cap) ov <= 1'b1;
            else        len <= len + LEN_W'(1);
            h0 <= dec_byte;
            h1 <= h0;
            h2 <= h1;
            if (len >= LEN_W'(2)) crc <= crc16_step(crc, h1);
            if (mine_n && !ov_n && (len >= LEN_W'(3))) begin
               out_valid <= 1'b1;
               out_data  <= h2;
               sent      <= 1'b1;
            end
         end
      end
   end

   logic [CNT_W-1:0] cnt_bus [NUM_EV];

   for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
      esc_rx_satcnt #(.W(CNT_W)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (cnt_clr),
         .inc  (ev_inc[g]),
         .count(cnt_bus[g])
      );
   end

   assign cnt_framing  = cnt_bus[IX_FRAMING];
   assign cnt_runt     = cnt_bus[IX_RUNT];
   assign cnt_oversize = cnt_bus[IX_OVERSIZE];
   assign cnt_badcrc   = cnt_bus[IX_BADCRC];
endmodule

// File: rtl/esc_frame_rx_chk.sv
module esc_frame_rx_chk
   import esc_rx_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_clr,
   input logic             in_valid,
   input logic             out_valid,
   input logic             out_last,
   input logic             out_accept,
   input logic [NUM_EV-1:0] ev_inc,
   input logic [CNT_W-1:0] cnt_framing,
   input logic [CNT_W-1:0] cnt_runt,
   input logic [CNT_W-1:0] cnt_oversize,
   input logic [CNT_W-1:0] cnt_badcrc
);
   a_r3_accept_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      out_accept |-> (out_valid && out_last));

   a_r2_beat_after_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   a_r12_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ev_inc) <= 1);

   a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt_framing == '0 && cnt_runt == '0 &&
                   cnt_oversize == '0 && cnt_badcrc == '0));

   a_r10_runt_holds_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_runt == {CNT_W{1'b1}} && !cnt_clr) |=> (cnt_runt == {CNT_W{1'b1}}));

   a_r10_framing_holds_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_framing == {CNT_W{1'b1}} && !cnt_clr) |=> (cnt_framing == {CNT_W{1'b1}}));

   a_r9_framing_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (cnt_framing == $past(cnt_framing) ||
                    cnt_framing == $past(cnt_framing) + 1'b1));

   a_r8_badcrc_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (cnt_badcrc == $past(cnt_badcrc) ||
                    cnt_badcrc == $past(cnt_badcrc) + 1'b1));
endmodule

bind esc_frame_rx esc_frame_rx_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt_clr     (cnt_clr),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_last    (out_last),
   .out_accept  (out_accept),
   .ev_inc      (ev_inc),
   .cnt_framing (cnt_framing),
   .cnt_runt    (cnt_runt),
   .cnt_oversize(cnt_oversize),
   .cnt_badcrc  (cnt_badcrc)
);

// File: tb/test_esc_frame_rx.sv
`timescale 1ns/1ps
module test_esc_frame_rx;
   localparam int MAXF = 69;
   localparam logic [7:0] ADDR  = 8'h2A;
   localparam logic [7:0] OTHER = 8'h55;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] my_addr = ADDR;
   logic       cnt_clr = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, out_last, out_accept;
   logic [7:0] out_data;
   logic [7:0] cnt_framing, cnt_runt, cnt_oversize, cnt_badcrc;

   always #2.5 clk = ~clk;

   esc_frame_rx i_esc_frame_rx (
      .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .cnt_clr(cnt_clr),
      .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_accept(out_accept),
      .cnt_framing(cnt_framing), .cnt_runt(cnt_runt),
      .cnt_oversize(cnt_oversize), .cnt_badcrc(cnt_badcrc)
   );

   int n_chk = 0;
   int n_err = 0;
   int e_fe = 0, e_runt = 0, e_ov = 0, e_crc = 0;
   logic [9:0] exp_q[$];     // {accept, last, data}
   logic [7:0] msg[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int upto);
      logic [15:0] c = 16'hFFFF;
      for (int n = 0; n < upto; n++) begin
         for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[15] ^ msg[n][i];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
         end
      end
      return c;
   endfunction

   // header: destination, source, control; then data; then CRC low, high
   task automatic make_msg(input logic [7:0] dst, input int plen, input int seed);
      logic [15:0] c;
      msg.delete();
      msg.push_back(dst);
      msg.push_back(8'h11);
      msg.push_back(8'h05);
      for (int i = 0; i < plen; i++) begin
         if (i == 1)      msg.push_back(8'hC0);
         else if (i == 2) msg.push_back(8'hDB);
         else             msg.push_back(8'((seed * 7 + i * 13) & 8'hFF));
      end
      c = ref_crc(msg.size());
      msg.push_back(c[7:0]);
      msg.push_back(c[15:8]);
   endtask

   task automatic raw(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
   endtask

   task automatic put(input logic [7:0] b);
      if (b == 8'hC0) begin raw(8'hDB); raw(8'hDC); end
      else if (b == 8'hDB) begin raw(8'hDB); raw(8'hDD); end
      else raw(b);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   function automatic int sat(input int v);
      return (v > 255) ? 255 : v;
   endfunction

   // ferr_at < 0: normal close; otherwise a broken escape after ferr_at bytes
   task automatic send(input int ferr_at, input int gap);
      int  k;
      bit  term, mine, cok;
      int  lim;
      term = (ferr_at < 0);
      k    = term ? msg.size() : ferr_at;
      mine = (k > 0) && (msg[0] == ADDR);
      cok  = (k >= 2) && (ref_crc(k - 2) == {msg[k-1], msg[k-2]});
      if (mine && k >= 4) begin
         lim = (k < MAXF) ? k : MAXF;
         for (int i = 0; i <= lim - 4; i++) exp_q.push_back({2'b00, msg[i]});
         exp_q.push_back({(term && k >= 5 && k <= MAXF && cok), 1'b1, msg[k-3]});
      end
      if (!term)           e_fe = sat(e_fe + 1);
      else if (k == 0)     ;
      else if (k > MAXF)   e_ov = sat(e_ov + 1);
      else if (k < 5)      begin if (mine) e_runt = sat(e_runt + 1); end
      else if (mine && !cok) e_crc = sat(e_crc + 1);

      for (int i = 0; i < k; i++) put(msg[i]);
      if (!term) begin
         raw(8'hDB);
         raw(8'h41);
         for (int i = k; i < msg.size(); i++) put(msg[i]);
      end
      raw(8'hC0);
      idle(gap);
   endtask

   task automatic check_counters(input string req);
      chk(cnt_framing  == 8'(e_fe),   req, "framing count",  cnt_framing,  e_fe);
      chk(cnt_runt     == 8'(e_runt), req, "runt count",     cnt_runt,     e_runt);
      chk(cnt_oversize == 8'(e_ov),   req, "oversize count", cnt_oversize, e_ov);
      chk(cnt_badcrc   == 8'(e_crc),  req, "bad-CRC count",  cnt_badcrc,   e_crc);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 R4", "unexpected beat", {out_accept, out_last, out_data}, 0);
         end else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            chk({out_accept, out_last, out_data} == e, "R2 R3",
                "beat {accept,last,data}", {out_accept, out_last, out_data}, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
      check_counters("R11");

      // R1 R2 R3: good addressed message with escaped bytes
      make_msg(ADDR, 8, 1);
      send(-1, 6);
      check_counters("R1");

      // R4: good message to another unit
      make_msg(OTHER, 8, 2);
      send(-1, 6);
      check_counters("R4");

      // R8: bad CRC, addressed
      make_msg(ADDR, 5, 3);
      msg[msg.size()-1] = msg[msg.size()-1] ^ 8'h01;
      send(-1, 6);
      check_counters("R8");

      // R4: bad CRC, other address, not counted
      make_msg(OTHER, 5, 4);
      msg[msg.size()-2] = msg[msg.size()-2] ^ 8'h80;
      send(-1, 6);
      check_counters("R4");

      // R5: back-to-back delimiters
      msg.delete();
      send(-1, 6);
      chk(exp_q.size() == 0, "R5", "pending beats", exp_q.size(), 0);
      check_counters("R5");

      // R6: runts of 3 and 4 bytes addressed, 2 bytes elsewhere
      msg = '{ADDR, 8'h11, 8'h05};
      send(-1, 6);
      check_counters("R6");
      msg = '{ADDR, 8'h11, 8'h05, 8'h77};
      send(-1, 6);
      check_counters("R6");
      msg = '{OTHER, 8'h11};
      send(-1, 6);
      check_counters("R4");

      // R3: exactly maximum length accepted
      make_msg(ADDR, 64, 5);
      send(-1, 6);
      check_counters("R3");

      // R7: one byte over, and an oversize message to another unit
      make_msg(ADDR, 65, 6);
      send(-1, 6);
      check_counters("R7");
      make_msg(OTHER, 70, 7);
      send(-1, 6);
      check_counters("R7");

      // R9 R12: broken escape inside an addressed message with a bad CRC
      make_msg(ADDR, 10, 8);
      msg[msg.size()-1] = msg[msg.size()-1] ^ 8'h10;
      send(6, 6);
      check_counters("R12");
      // R9: broken escape right after the first byte, then recovery
      make_msg(ADDR, 4, 9);
      send(1, 6);
      check_counters("R9");
      make_msg(ADDR, 6, 10);
      send(-1, 6);
      check_counters("R9");

      // R10: saturation of the runt counter
      for (int n = 0; n < 260; n++) begin
         msg = '{ADDR, 8'(n), 8'h05};
         send(-1, 1);
      end
      idle(6);
      chk(cnt_runt == 8'hFF, "R10", "runt count saturated", cnt_runt, 255);
      check_counters("R10");

      // R11: synchronous clear
      @(negedge clk);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      e_fe = 0; e_runt = 0; e_ov = 0; e_crc = 0;
      check_counters("R11");

      idle(4);
      chk(exp_q.size() == 0, "R2", "beats never produced", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule